// File: doc/BRIEF.md
# Flash embedded-operation status responder

This block produces the status a parallel NOR flash device shows while an internal program or erase is running. A one-cycle command-complete strobe, taken as the rising edge of the last write-enable pulse of a command sequence, starts an operation. Until the operation finishes, the block pulls an open-drain ready/busy line low. It also replaces array data on the read bus with a status byte whose bit 6 inverts on every read cycle.

Completion of a real operation comes from outside on `op_finish`, because the array and its real timing are not part of this block. A command aimed at a protected target starts no operation. Instead it gives a fixed busy window, counted in clock cycles: a long one for erase and a short one for program. The default lengths are derived from a clock-frequency parameter. An erase can be suspended and resumed. A program can run while the erase is suspended. A fault input latches a sticky timeout flag in bit 5, and that flag holds the device busy until a reset command arrives.

Top module: `flash_status_responder`

## Requirements
- R1: After synchronous reset the block is in read mode: `rdy_pull_low` is 0, `status_out` equals `array_data`, and the timeout flag and bit 6 are 0.
- R2: A `cmd_done` taken in read mode for an unprotected target makes `rdy_pull_low` 1 from the next cycle. `status_out` then carries bit 6 = 0 for the first read.
- R3: While busy, each cycle with `rd_oe` or `rd_ce` high inverts bit 6 as seen by the next read. A cycle with both strobes high counts once. Read strobes while not busy change nothing.
- R4: `op_finish` during a running program or erase with no timeout latched returns the block to read mode on the next cycle: `rdy_pull_low` 0, `status_out` = `array_data`.
- R5: An erase command to a protected target holds busy with toggling for exactly `ERS_WIN_CYC` cycles, then returns to read mode.
- R6: A program command to a protected target holds busy for exactly `PGM_WIN_CYC` cycles. It then returns to the mode it came from: read, or erase-suspended.
- R7: `suspend_req` during an erase moves the block to erase-suspended read. There `rdy_pull_low` is 0, `status_out` = `array_data`, and bit 6 holds. `suspend_req` during a program has no effect.
- R8: In erase suspend, a program command runs busy, and `op_finish` returns to erase suspend. An erase command is ignored there. `resume_req` restarts the erase, which is busy again.
- R9: `fault_in` while busy sets bit 5 (sticky). While bit 5 is set, the busy state cannot be left by finish, window expiry or suspend. `reset_cmd` clears bit 5 and returns to read mode from any state.
- R10: `cmd_done` while busy is ignored.
- R11: While busy, status bit 7 and bits 4..0 read 0. The toggle sits in bit 6 and the timeout flag in bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_done | input | 1 | Command sequence complete strobe |
| cmd_erase | input | 1 | Operation type with `cmd_done`: 1 erase, 0 program |
| target_prot | input | 1 | Target sector(s) protected, with `cmd_done` |
| suspend_req | input | 1 | Erase suspend request strobe |
| resume_req | input | 1 | Erase resume request strobe |
| reset_cmd | input | 1 | Reset command strobe |
| op_finish | input | 1 | Real operation finished strobe |
| fault_in | input | 1 | Injected operation fault |
| rd_oe | input | 1 | Read cycle marked by output enable |
| rd_ce | input | 1 | Read cycle marked by chip enable |
| array_data | input | 8 | Array data returned in non-busy modes |
| status_out | output | 8 | Read data: status byte when busy, else array data |
| rdy_pull_low | output | 1 | Open-drain enable: 1 pulls ready/busy low |

## Verification
The hardest situation to reach is a program that runs inside an erase suspend, including a protected one whose short window must return to suspend and not to read mode. It needs an erase, a suspend and a second command in order, with no finish or reset in between. Directed sequences build that chain explicitly and also count protected windows cycle by cycle. The random phase then mixes rare faults and reset commands into long busy stretches, so that faults can interrupt windows, suspended programs and resumed erases.

// File: rtl/fsr_pkg.sv
// Shared types for the flash status responder.
// Assumes: one status byte, toggle and timeout bit positions fixed here.
package fsr_pkg;
    typedef enum logic [2:0] {
        ST_READ  = 3'd0,
        ST_PGM   = 3'd1,
        ST_ERS   = 3'd2,
        ST_PROT  = 3'd3,
        ST_SUSP  = 3'd4,
        ST_SPGM  = 3'd5,
        ST_SPROT = 3'd6
    } fsr_state_e;

    localparam int STAT_W  = 8;
    localparam int TOG_POS = 6;
    localparam int TMO_POS = 5;
endpackage

// File: rtl/fsr_win_timer.sv
// Down-counter for the protected-target busy windows.
// Assumes: load and run are never both needed in one cycle; expired is
// high while the count is zero, so a window of N cycles loads N-1.
module fsr_win_timer #(
    parameter int LONG_CYC  = 10000,
    parameter int SHORT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_long,
    input  logic run,
    output logic expired
);
    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] LONG_INIT  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_INIT = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Load the window length or count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_long ? LONG_INIT : SHORT_INIT;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Window over when the count has reached zero.
    always_comb expired = (cnt_q == '0);
endmodule

// File: rtl/fsr_seq.sv
// Mode sequencer: read, running program/erase, protected windows,
// erase suspend and program inside suspend.
// Assumes: strobes are single-cycle; a latched fault blocks every exit
// except the reset command.
module fsr_seq
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_done,
    input  logic       cmd_erase,
    input  logic       target_prot,
    input  logic       suspend_req,
    input  logic       resume_req,
    input  logic       reset_cmd,
    input  logic       op_finish,
    input  logic       fault_q,
    input  logic       win_expired,
    output fsr_state_e state,
    output logic       busy,
    output logic       start,
    output logic       win_load,
    output logic       win_long,
    output logic       win_run
);
    fsr_state_e nxt;

    // Next-mode decision and command acceptance.
    always_comb begin
        nxt      = state;
        start    = 1'b0;
        win_load = 1'b0;
        win_long = cmd_erase;
        if (reset_cmd) begin
            nxt = ST_READ;
        end else begin
            unique case (state)
                ST_READ: begin
                    if (cmd_done) begin
                        start = 1'b1;
                        if (target_prot) begin
                            win_load = 1'b1;
                            nxt      = ST_PROT;
                        end else begin
                            nxt = cmd_erase ? ST_ERS : ST_PGM;
                        end
                    end
                end
                ST_PGM: begin
                    if (op_finish && !fault_q) nxt = ST_READ;
                end
                ST_ERS: begin
                    if (!fault_q) begin
                        if (op_finish)        nxt = ST_READ;
                        else if (suspend_req) nxt = ST_SUSP;
                    end
                end
                ST_PROT: begin
                    if (win_expired && !fault_q) nxt = ST_READ;
                end
                ST_SUSP: begin
                    if (cmd_done && !cmd_erase) begin
                        start = 1'b1;
                        if (target_prot) begin
                            win_load = 1'b1;
                            nxt      = ST_SPROT;
                        end else begin
                            nxt = ST_SPGM;
                        end
                    end else if (resume_req) begin
                        nxt = ST_ERS;
                    end
                end
                ST_SPGM: begin
                    if (op_finish && !fault_q) nxt = ST_SUSP;
                end
                ST_SPROT: begin
                    if (win_expired && !fault_q) nxt = ST_SUSP;
                end
                default: nxt = ST_READ;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    // Busy decode and window run enable.
    always_comb begin
        busy    = (state == ST_PGM) || (state == ST_ERS) || (state == ST_PROT) ||
                  (state == ST_SPGM) || (state == ST_SPROT);
        win_run = ((state == ST_PROT) || (state == ST_SPROT)) && !fault_q;
    end
endmodule

// File: rtl/fsr_toggle.sv
// Read-driven toggle bit: inverts once per read cycle while enabled.
// Assumes: both read strobes in one cycle are one read; clear wins.
module fsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    input  logic rd_oe,
    input  logic rd_ce,
    output logic tog
);
    logic rd_any;

    // Merge the two read markers into one read event.
    always_comb rd_any = rd_oe | rd_ce;

    // Toggle register.
    always_ff @(posedge clk) begin
        if (!rst_n)             tog <= 1'b0;
        else if (clear)         tog <= 1'b0;
        else if (en && rd_any)  tog <= ~tog;
    end
endmodule

// File: rtl/fsr_fault_latch.sv
// Sticky timeout flag.
// Assumes: clear has priority over set.
module fsr_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else if (set) flag <= 1'b1;
    end
endmodule

// File: rtl/flash_status_responder.sv
// Status side of a parallel NOR flash during embedded operations.
// Assumes: all inputs synchronous to clk; array_data is supplied by the
// surrounding array model; window lengths are in clock cycles.
module flash_status_responder
    import fsr_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int ERS_PROT_US = 100,
    parameter int PGM_PROT_US = 1,
    parameter int ERS_WIN_CYC = CLK_MHZ * ERS_PROT_US,
    parameter int PGM_WIN_CYC = CLK_MHZ * PGM_PROT_US
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic              cmd_erase,
    input  logic              target_prot,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              reset_cmd,
    input  logic              op_finish,
    input  logic              fault_in,
    input  logic              rd_oe,
    input  logic              rd_ce,
    input  logic [STAT_W-1:0] array_data,
    output logic [STAT_W-1:0] status_out,
    output logic              rdy_pull_low
);
    fsr_state_e seq_state;
    logic       busy;
    logic       start;
    logic       win_load;
    logic       win_long;
    logic       win_run;
    logic       win_expired;
    logic       tog_q;
    logic       fault_q;

    fsr_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_done    (cmd_done),
        .cmd_erase   (cmd_erase),
        .target_prot (target_prot),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .reset_cmd   (reset_cmd),
        .op_finish   (op_finish),
        .fault_q     (fault_q),
        .win_expired (win_expired),
        .state       (seq_state),
        .busy        (busy),
        .start       (start),
        .win_load    (win_load),
        .win_long    (win_long),
        .win_run     (win_run)
    );

    fsr_win_timer #(
        .LONG_CYC  (ERS_WIN_CYC),
        .SHORT_CYC (PGM_WIN_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (win_load),
        .load_long (win_long),
        .run       (win_run),
        .expired   (win_expired)
    );

    fsr_toggle u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .en    (busy),
        .rd_oe (rd_oe),
        .rd_ce (rd_ce),
        .tog   (tog_q)
    );

    fsr_fault_latch u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (busy & fault_in),
        .clr   (reset_cmd),
        .flag  (fault_q)
    );

    // Read data: status byte while busy, array data otherwise.
    always_comb begin
        status_out = array_data;
        if (busy) begin
            status_out          = '0;
            status_out[TOG_POS] = tog_q;
            status_out[TMO_POS] = fault_q;
        end
    end

    // Open-drain enable: pull the shared line low while busy.
    always_comb rdy_pull_low = busy;
endmodule

// File: rtl/fsr_chk.sv
// Property checker for flash_status_responder, attached by bind.
module fsr_chk
    import fsr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_done,
    input logic       suspend_req,
    input logic       reset_cmd,
    input logic       op_finish,
    input logic       rd_oe,
    input logic       rd_ce,
    input logic [7:0] array_data,
    input logic [7:0] status_out,
    input logic       rdy_pull_low,
    input fsr_state_e state,
    input logic       tog,
    input logic       tmo
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && cmd_done && !reset_cmd) |=> rdy_pull_low);

    // R3
    read_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_pull_low && (rd_oe || rd_ce)) |=> (tog != $past(tog)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_pull_low && !cmd_done) |=> $stable(tog));

    // R4
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_pull_low |-> (status_out == array_data));

    // R7
    suspend_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS && suspend_req && !op_finish && !tmo && !reset_cmd)
        |=> !rdy_pull_low);

    // R9
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !reset_cmd) |=> tmo);

    // R9
    tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && rdy_pull_low && !reset_cmd) |=> rdy_pull_low);

    // R10
    cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM && cmd_done && !op_finish && !reset_cmd) |=> (state == ST_PGM));

    // R11
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_pull_low |-> (status_out[7] == 1'b0 && status_out[4:0] == 5'd0));
endmodule

bind flash_status_responder fsr_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_done     (cmd_done),
    .suspend_req  (suspend_req),
    .reset_cmd    (reset_cmd),
    .op_finish    (op_finish),
    .rd_oe        (rd_oe),
    .rd_ce        (rd_ce),
    .array_data   (array_data),
    .status_out   (status_out),
    .rdy_pull_low (rdy_pull_low),
    .state        (seq_state),
    .tog          (tog_q),
    .tmo          (fault_q)
);

// File: tb/flash_status_responder_test.sv
module flash_status_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int ERS_N      = 40;
    localparam int PGM_N      = 6;
    localparam int WDOG_CYC   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       rst_n;
    logic       cmd_done, cmd_erase, target_prot, suspend_req, resume_req;
    logic       reset_cmd, op_finish, fault_in, rd_oe, rd_ce;
    logic [7:0] array_data;
    logic [7:0] status_out;
    logic       rdy_pull_low;
    wire        rdy_line;

    // Shared ready/busy line with a pull-up and one open-drain driver.
    assign rdy_line = rdy_pull_low ? 1'b0 : 1'b1;

    flash_status_responder #(
        .ERS_WIN_CYC (ERS_N),
        .PGM_WIN_CYC (PGM_N)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_erase(cmd_erase),
        .target_prot(target_prot), .suspend_req(suspend_req), .resume_req(resume_req),
        .reset_cmd(reset_cmd), .op_finish(op_finish), .fault_in(fault_in),
        .rd_oe(rd_oe), .rd_ce(rd_ce), .array_data(array_data),
        .status_out(status_out), .rdy_pull_low(rdy_pull_low)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model: 0 read, 1 program, 2 erase, 3 protected window,
    // 4 erase suspend, 5 program in suspend, 6 protected window in suspend.
    int   m_mode;
    logic m_tog, m_fault;
    int   m_cnt;

    function automatic bit m_busy(int md);
        return (md == 1) || (md == 2) || (md == 3) || (md == 5) || (md == 6);
    endfunction

    function automatic logic [7:0] exp_status(int md, logic t, logic f, logic [7:0] arr);
        if (m_busy(md)) return {1'b0, t, f, 5'b0};
        return arr;
    endfunction

    function automatic string tag_of(int md);
        case (md)
            0: return "R4";
            1, 2: return "R3";
            3: return "R5";
            4: return "R7";
            5: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit   bz = m_busy(m_mode);
        int   nx = m_mode;
        int   nc = m_cnt;
        logic nt = m_tog;
        logic nf = m_fault;
        bit   st = 0;
        if (bz && (rd_oe || rd_ce)) nt = ~m_tog;
        if (bz && fault_in) nf = 1'b1;
        if ((m_mode == 3 || m_mode == 6) && !m_fault && m_cnt > 0) nc = m_cnt - 1;
        if (reset_cmd) begin
            nx = 0; nf = 1'b0;
        end else begin
            case (m_mode)
                0: if (cmd_done) begin
                       st = 1;
                       if (target_prot) begin nx = 3; nc = cmd_erase ? ERS_N-1 : PGM_N-1; end
                       else nx = cmd_erase ? 2 : 1;
                   end
                1: if (op_finish && !m_fault) nx = 0;
                2: if (!m_fault) begin
                       if (op_finish) nx = 0;
                       else if (suspend_req) nx = 4;
                   end
                3: if (!m_fault && m_cnt == 0) nx = 0;
                4: if (cmd_done && !cmd_erase) begin
                       st = 1;
                       if (target_prot) begin nx = 6; nc = PGM_N-1; end
                       else nx = 5;
                   end else if (resume_req) nx = 2;
                5: if (op_finish && !m_fault) nx = 4;
                default: if (!m_fault && m_cnt == 0) nx = 4;
            endcase
        end
        if (st) nt = 1'b0;
        m_mode = nx; m_cnt = nc; m_tog = nt; m_fault = nf;
    endtask

    // One cycle: compare outputs against the model, clock, advance model.
    task automatic tick();
        logic [7:0] es;
        #1;
        es = exp_status(m_mode, m_tog, m_fault, array_data);
        check(rdy_line == !m_busy(m_mode), tag_of(m_mode), {15'd0, rdy_line}, {15'd0, !m_busy(m_mode)});
        check(status_out == es, tag_of(m_mode), {8'd0, status_out}, {8'd0, es});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic quiet();
        cmd_done = 0; cmd_erase = 0; target_prot = 0; suspend_req = 0; resume_req = 0;
        reset_cmd = 0; op_finish = 0; fault_in = 0; rd_oe = 0; rd_ce = 0;
    endtask

    task automatic issue(bit ers, bit prot);
        cmd_done = 1; cmd_erase = ers; target_prot = prot;
        tick(); quiet();
    endtask

    task automatic window_len(string tag, int expn);
        int n = 0;
        #1;
        while (rdy_line == 1'b0 && n < 1000) begin
            n++;
            tick();
            #1;
        end
        check(n == expn, tag, 16'(n), 16'(expn));
    endtask

    initial begin : watchdog
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic b0, b1;
        void'($urandom(32'd20477));
        quiet();
        rst_n = 0; array_data = 8'hA5;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(rdy_line == 1'b1, "R1", {15'd0, rdy_line}, 16'd1);
        check(status_out == 8'hA5, "R1", {8'd0, status_out}, 16'h00A5);
        rst_n = 1;
        m_mode = 0; m_tog = 0; m_fault = 0; m_cnt = 0;
        @(negedge clk);
        tick();

        // R2: program start, first read has bit 6 = 0
        issue(0, 0);
        #1;
        check(rdy_line == 1'b0, "R2", {15'd0, rdy_line}, 16'd0);
        check(status_out == 8'h00, "R2", {8'd0, status_out}, 16'h0000);
        // R3: reads through OE, CE and both together each flip once
        b0 = status_out[6];
        rd_oe = 1; tick(); quiet(); #1; b1 = status_out[6];
        check(b1 == ~b0, "R3", {15'd0, b1}, {15'd0, ~b0});
        rd_ce = 1; tick(); quiet(); #1; b0 = status_out[6];
        check(b0 == ~b1, "R3", {15'd0, b0}, {15'd0, ~b1});
        rd_oe = 1; rd_ce = 1; tick(); quiet(); #1; b1 = status_out[6];
        check(b1 == ~b0, "R3", {15'd0, b1}, {15'd0, ~b0});
        tick(); #1;
        check(status_out[6] == b1, "R3", {15'd0, status_out[6]}, {15'd0, b1});
        // R10: erase command while busy is ignored
        issue(1, 0);
        // R7: suspend during program has no effect
        suspend_req = 1; tick(); quiet(); #1;
        check(rdy_line == 1'b0, "R7", {15'd0, rdy_line}, 16'd0);
        // R4: finish returns to array reads
        op_finish = 1; tick(); quiet(); array_data = 8'h3C; #1;
        check(rdy_line == 1'b1 && status_out == 8'h3C, "R4", {7'd0, rdy_line, status_out}, 16'h013C);

        // R5: protected erase window
        issue(1, 1);
        window_len("R5", ERS_N);
        // R6: protected program window
        issue(0, 1);
        window_len("R6", PGM_N);

        // R7: erase then suspend
        issue(1, 0);
        rd_oe = 1; tick(); quiet();
        suspend_req = 1; tick(); quiet(); array_data = 8'h5A; #1;
        check(rdy_line == 1'b1 && status_out == 8'h5A, "R7", {7'd0, rdy_line, status_out}, 16'h015A);
        rd_ce = 1; tick(); quiet();
        // R8: erase in suspend ignored, program in suspend runs and returns
        issue(1, 0); #1;
        check(rdy_line == 1'b1, "R8", {15'd0, rdy_line}, 16'd1);
        issue(0, 0); #1;
        check(rdy_line == 1'b0, "R8", {15'd0, rdy_line}, 16'd0);
        op_finish = 1; tick(); quiet(); #1;
        check(rdy_line == 1'b1 && m_mode == 4, "R8", {15'd0, rdy_line}, 16'd1);
        // R6: protected program inside suspend returns to suspend
        issue(0, 1);
        window_len("R6", PGM_N);
        check(m_mode == 4, "R6", 16'(m_mode), 16'd4);
        resume_req = 1; tick(); quiet(); #1;
        check(rdy_line == 1'b0, "R8", {15'd0, rdy_line}, 16'd0);

        // R9: fault latches, blocks finish and suspend, reset clears
        fault_in = 1; tick(); quiet(); #1;
        check(status_out[5] == 1'b1, "R9", {15'd0, status_out[5]}, 16'd1);
        // R11: spare bits zero while busy
        check(status_out[7] == 1'b0 && status_out[4:0] == 5'd0, "R11", {8'd0, status_out}, 16'h0020);
        op_finish = 1; tick(); quiet();
        suspend_req = 1; tick(); quiet(); #1;
        check(rdy_line == 1'b0, "R9", {15'd0, rdy_line}, 16'd0);
        reset_cmd = 1; tick(); quiet(); #1;
        check(rdy_line == 1'b1, "R9", {15'd0, rdy_line}, 16'd1);
        issue(0, 0); #1;
        check(status_out[5] == 1'b0, "R9", {15'd0, status_out[5]}, 16'd0);
        op_finish = 1; tick(); quiet();

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            cmd_done    = ($urandom % 100) < 5;
            cmd_erase   = ($urandom % 2) == 1;
            target_prot = ($urandom % 100) < 20;
            suspend_req = ($urandom % 100) < 4;
            resume_req  = ($urandom % 100) < 5;
            op_finish   = ($urandom % 100) < 4;
            fault_in    = ($urandom % 1000) < 4;
            reset_cmd   = ($urandom % 1000) < 6;
            rd_oe       = ($urandom % 100) < 30;
            rd_ce       = ($urandom % 100) < 30;
            array_data  = 8'($urandom);
            tick();
        end
        quiet();
        reset_cmd = 1; tick(); quiet();
        tick();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule